// File: doc/BRIEF.md
# Memory-Mapped Stream Link Bridge

This peripheral joins a simple 32-bit memory-mapped register bus to a pair of valid/ready streams, one outgoing and one incoming. Each stream has its own FIFO, and each FIFO entry holds 32 data bits plus an end-of-stream flag.

Software pushes outgoing words by writing one of two data addresses. The address it picks decides whether the word closes a stream. Software pops incoming words by reading a receive data address. The end-of-stream flag of the popped word appears in the control register. The control register also holds an enable bit, which flushes both FIFOs when it is cleared, and shows the empty, half-full and full state of each FIFO.

The receive stream's end-of-stream input may be tied low. Every incoming word is then reported as not ending a stream.

Top module: `mm_stream_bridge`

## Requirements
- R1: After reset the enable bit is 0, both FIFOs are empty, `tx_tvalid` and `rx_tready` are low, and a control read returns 0x00010100.
- R2: A write to byte offset 8 (address bit 3 set, bit 2 clear) pushes the written word into the transmit FIFO with its end flag clear, so that beat leaves with `tx_tlast` low.
- R3: A write to byte offset 12 (bits 3 and 2 set) pushes the word with its end flag set, so that beat leaves with `tx_tlast` high.
- R4: Writes to offset 4 or offset 0 never push into the transmit FIFO.
- R5: `tx_tvalid` is high exactly while the transmit FIFO holds an entry. An entry leaves only on a cycle with `tx_tvalid` and `tx_tready` both high. Words leave in write order, and `tx_tdata`/`tx_tlast` hold steady while the beat is stalled.
- R6: `rx_tready` is high while the block is enabled and the receive FIFO is not full. Each accepted beat stores `rx_tdata` together with `rx_tlast`, in arrival order.
- R7: A read of offset 4 pops one receive entry and returns its data. Control bit 1 then reports that entry's end flag.
- R8: A read of offset 4 while the receive FIFO is empty returns 0, clears control bit 1, and leaves the FIFO unchanged.
- R9: Transmit writes made while the transmit FIFO is full are dropped.
- R10: The control read layout is: bit 0 enable, bit 1 last-popped end flag, bits 8/9/10 receive empty/half/full, and bits 16/17/18 transmit empty/half/full. "Half" means the entry count is at least depth/2.
- R11: Writing 0 to control bit 0 clears the enable and empties both FIFOs.
- R12: Each bus access with `bus_stb` high is acknowledged by `bus_ack` on the next cycle, with `bus_rdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access acknowledge |
| tx_tdata | output | 32 | Outgoing stream data |
| tx_tlast | output | 1 | Outgoing end-of-stream flag |
| tx_tvalid | output | 1 | Outgoing beat available |
| tx_tready | input | 1 | Sink accepts outgoing beat |
| rx_tdata | input | 32 | Incoming stream data |
| rx_tlast | input | 1 | Incoming end-of-stream flag, may be tied low |
| rx_tvalid | input | 1 | Incoming beat available |
| rx_tready | output | 1 | Block accepts incoming beat |

## Verification
The bench checks that the push decode looks at address bit 3. A decoder keyed on bit 2 would push on the receive data address and lose writes to offset 8. It checks that bit 2 alone sets the end flag, so a swapped or dropped flag shows up on `tx_tlast`. It fills the transmit FIFO past its depth and drains it: a FIFO that accepts a ninth word would show it as a stray extra beat or a corrupted sequence. It also reads the empty receive FIFO before sending a word and then flushes both FIFOs, which catches pointer movement on an empty pop and a flush that leaves stale entries behind.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = WORD_W + 1;

  // Word offsets (byte address bits 3:2)
  localparam logic [1:0] OFS_CTRL    = 2'd0;
  localparam logic [1:0] OFS_RX_DATA = 2'd1;

  // Control register bit positions
  localparam int unsigned CB_EN       = 0;
  localparam int unsigned CB_RX_LAST  = 1;
  localparam int unsigned CB_RX_EMPTY = 8;
  localparam int unsigned CB_RX_HALF  = 9;
  localparam int unsigned CB_RX_FULL  = 10;
  localparam int unsigned CB_TX_EMPTY = 16;
  localparam int unsigned CB_TX_HALF  = 17;
  localparam int unsigned CB_TX_FULL  = 18;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } fifo_stat_t;
endpackage

// File: rtl/sl_fifo.sv
module sl_fifo #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output sl_pkg::fifo_stat_t stat
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULL_CNT) && !clr;
  assign do_pop  = pop  && (count != '0) && !clr;

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout       = mem[rptr];
  assign stat.empty = (count == '0);
  assign stat.full  = (count == FULL_CNT);
  assign stat.half  = (count >= HALF_CNT);

  // R9: occupancy never passes the depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  // R9: a push into a full FIFO without a pop leaves it unchanged
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (stat.full && push && !pop && !clr) |=> (count == $past(count)));
  // R8: a pop of an empty FIFO without a push leaves it unchanged
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (stat.empty && pop && !push && !clr) |=> (count == $past(count)));
  // R6: an accepted push grows occupancy by one
  assert_push_grows_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !stat.full && !pop && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/sl_regs.sv
module sl_regs
  import sl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_stb,
  input  logic               bus_we,
  input  logic [1:0]         word_ofs,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_ack,
  output logic               en,
  output logic               tx_push,
  output logic [ENTRY_W-1:0] tx_entry,
  output logic               rx_pop,
  input  logic [ENTRY_W-1:0] rx_entry,
  input  fifo_stat_t         rx_stat,
  input  fifo_stat_t         tx_stat
);
  logic              rx_last_q;
  logic              rd_ctrl, rd_rx, wr_ctrl;
  logic [WORD_W-1:0] ctrl_word;

  // Bit 3 of the byte address selects the transmit pair, bit 2 marks end of stream
  assign tx_push  = bus_stb && bus_we && word_ofs[1];
  assign tx_entry = {word_ofs[0], bus_wdata};
  assign rx_pop   = bus_stb && !bus_we && (word_ofs == OFS_RX_DATA);
  assign rd_ctrl  = bus_stb && !bus_we && (word_ofs == OFS_CTRL);
  assign rd_rx    = rx_pop;
  assign wr_ctrl  = bus_stb && bus_we && (word_ofs == OFS_CTRL);

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CB_EN]       = en;
    ctrl_word[CB_RX_LAST]  = rx_last_q;
    ctrl_word[CB_RX_EMPTY] = rx_stat.empty;
    ctrl_word[CB_RX_HALF]  = rx_stat.half;
    ctrl_word[CB_RX_FULL]  = rx_stat.full;
    ctrl_word[CB_TX_EMPTY] = tx_stat.empty;
    ctrl_word[CB_TX_HALF]  = tx_stat.half;
    ctrl_word[CB_TX_FULL]  = tx_stat.full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      rx_last_q <= 1'b0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= bus_stb;
      if (wr_ctrl) en <= bus_wdata[CB_EN];
      if (rd_rx) begin
        if (rx_stat.empty) begin
          bus_rdata <= '0;
          rx_last_q <= 1'b0;
        end else begin
          bus_rdata <= rx_entry[WORD_W-1:0];
          rx_last_q <= rx_entry[WORD_W];
        end
      end else if (rd_ctrl) begin
        bus_rdata <= ctrl_word;
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  // R12: every strobe is acknowledged on the next cycle
  assert_ack_follows_R12: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> bus_ack);
  // R12: no acknowledge without a strobe
  assert_no_spurious_ack_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_stb |=> !bus_ack);
  // R8: an empty receive pop reads as zero
  assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && rx_stat.empty) |=> (bus_rdata == '0));
endmodule

// File: rtl/mm_stream_bridge.sv
module mm_stream_bridge #(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_stb,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic [31:0] tx_tdata,
  output logic        tx_tlast,
  output logic        tx_tvalid,
  input  logic        tx_tready,
  input  logic [31:0] rx_tdata,
  input  logic        rx_tlast,
  input  logic        rx_tvalid,
  output logic        rx_tready
);
  import sl_pkg::*;

  logic               en, flush;
  logic               tx_push, tx_pop, rx_push, rx_pop;
  logic [ENTRY_W-1:0] tx_entry, tx_head, rx_head;
  fifo_stat_t         tx_stat, rx_stat;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^bus_addr[1:0];
  assign flush = !en;

  sl_regs i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .word_ofs  (bus_addr[3:2]),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .en        (en),
    .tx_push   (tx_push),
    .tx_entry  (tx_entry),
    .rx_pop    (rx_pop),
    .rx_entry  (rx_head),
    .rx_stat   (rx_stat),
    .tx_stat   (tx_stat)
  );

  sl_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk  (clk),
    .rst  (rst),
    .clr  (flush),
    .push (tx_push),
    .din  (tx_entry),
    .pop  (tx_pop),
    .dout (tx_head),
    .stat (tx_stat)
  );

  sl_fifo #(.W(ENTRY_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk  (clk),
    .rst  (rst),
    .clr  (flush),
    .push (rx_push),
    .din  ({rx_tlast, rx_tdata}),
    .pop  (rx_pop),
    .dout (rx_head),
    .stat (rx_stat)
  );

  assign tx_tvalid = !tx_stat.empty;
  assign tx_tdata  = tx_head[WORD_W-1:0];
  assign tx_tlast  = tx_head[WORD_W];
  assign tx_pop    = tx_tvalid && tx_tready;

  assign rx_tready = en && !rx_stat.full;
  assign rx_push   = rx_tvalid && rx_tready;

  // R5: a stalled beat keeps its contents until taken or flushed
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_tvalid && !tx_tready && en) |=>
      (!en || (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast))));
  // R6: no incoming beat is accepted while disabled
  assert_rx_closed_R6: assert property (@(posedge clk) disable iff (rst)
    !en |-> !rx_tready);
  // R11: after a flush both FIFOs are empty
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (tx_stat.empty && rx_stat.empty));
endmodule

// File: tb/test_mm_stream_bridge.sv
module test_mm_stream_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [31:0] tx_tdata;
  logic        tx_tlast, tx_tvalid;
  logic        tx_tready = 1'b0;
  logic [31:0] rx_tdata = '0;
  logic        rx_tlast = 1'b0, rx_tvalid = 1'b0;
  logic        rx_tready;

  int n_checks = 0;
  int n_fail = 0;

  mm_stream_bridge #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) i_mm_stream_bridge (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .tx_tdata(tx_tdata), .tx_tlast(tx_tlast),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .rx_tdata(rx_tdata),
    .rx_tlast(rx_tlast), .rx_tvalid(rx_tvalid), .rx_tready(rx_tready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_stb = 1'b0;
    check("R12 ack", {31'b0, bus_ack}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic tx_take(input string req, input logic [31:0] d, input logic l);
    @(negedge clk);
    check({req, " tvalid"}, {31'b0, tx_tvalid}, 32'd1);
    check({req, " tdata"}, tx_tdata, d);
    check({req, " tlast"}, {31'b0, tx_tlast}, {31'b0, l});
    tx_tready = 1'b1;
    @(negedge clk);
    tx_tready = 1'b0;
  endtask

  task automatic rx_give(input string req, input logic [31:0] d, input logic l);
    @(negedge clk);
    check({req, " tready"}, {31'b0, rx_tready}, 32'd1);
    rx_tvalid = 1'b1; rx_tdata = d; rx_tlast = l;
    @(negedge clk);
    rx_tvalid = 1'b0; rx_tlast = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    @(negedge clk);
    check("R1 tvalid", {31'b0, tx_tvalid}, 32'd0);
    check("R1 tready", {31'b0, rx_tready}, 32'd0);
    bus_read(4'd0, r);
    check("R1 ctrl", r, 32'h0001_0100);
    bus_write(4'd0, 32'd1);
    bus_read(4'd0, r);
    check("R10 ctrl enabled", r, 32'h0001_0101);
  endtask

  task automatic t_tx_plain();
    bus_write(4'd8, 32'hA5A5_0001);
    repeat (2) @(negedge clk);
    check("R5 stalled data", tx_tdata, 32'hA5A5_0001);
    tx_take("R2 plain", 32'hA5A5_0001, 1'b0);
    @(negedge clk);
    check("R5 empty after pop", {31'b0, tx_tvalid}, 32'd0);
  endtask

  task automatic t_tx_last();
    bus_write(4'd12, 32'h0BAD_F00D);
    tx_take("R3 last", 32'h0BAD_F00D, 1'b1);
  endtask

  task automatic t_no_push();
    bus_write(4'd4, 32'h1234_5678);
    bus_write(4'd0, 32'h0000_0F01);
    @(negedge clk);
    check("R4 no push", {31'b0, tx_tvalid}, 32'd0);
  endtask

  task automatic t_tx_order();
    bus_write(4'd8, 32'h11);
    bus_write(4'd12, 32'h22);
    bus_write(4'd8, 32'h33);
    tx_take("R5 order0", 32'h11, 1'b0);
    tx_take("R5 order1", 32'h22, 1'b1);
    tx_take("R5 order2", 32'h33, 1'b0);
  endtask

  task automatic t_rx();
    logic [31:0] r;
    rx_give("R6 beat0", 32'hCAFE_0000, 1'b0);
    rx_give("R6 beat1", 32'hCAFE_0001, 1'b1);
    bus_read(4'd4, r);
    check("R7 data0", r, 32'hCAFE_0000);
    bus_read(4'd0, r);
    check("R7 last0", {31'b0, r[1]}, 32'd0);
    bus_read(4'd4, r);
    check("R7 data1", r, 32'hCAFE_0001);
    bus_read(4'd0, r);
    check("R7 last1", {31'b0, r[1]}, 32'd1);
  endtask

  task automatic t_rx_empty();
    logic [31:0] r;
    bus_read(4'd4, r);
    check("R8 empty read", r, 32'd0);
    bus_read(4'd0, r);
    check("R8 last cleared", r, 32'h0001_0101);
    rx_give("R8 beat", 32'h0000_BEEF, 1'b0);
    bus_read(4'd4, r);
    check("R8 pointers intact", r, 32'h0000_BEEF);
  endtask

  task automatic t_full();
    logic [31:0] r;
    for (int i = 0; i < DEPTH/2; i++) bus_write(4'd8, 32'h100 + i);
    bus_read(4'd0, r);
    check("R10 tx half", r, 32'h0002_0101);
    for (int i = DEPTH/2; i < DEPTH; i++) bus_write(4'd8, 32'h100 + i);
    bus_read(4'd0, r);
    check("R10 tx full", r, 32'h0006_0101);
    bus_write(4'd12, 32'hDEAD);
    for (int i = 0; i < DEPTH; i++) tx_take("R9 drain", 32'h100 + i, 1'b0);
    @(negedge clk);
    check("R9 dropped word", {31'b0, tx_tvalid}, 32'd0);
    for (int i = 0; i < DEPTH; i++) rx_give("R6 fill", 32'h200 + i, 1'b0);
    @(negedge clk);
    check("R6 tready low when full", {31'b0, rx_tready}, 32'd0);
    bus_read(4'd0, r);
    check("R10 rx full", r, 32'h0001_0601);
  endtask

  task automatic t_flush();
    logic [31:0] r;
    bus_write(4'd8, 32'h77);
    bus_write(4'd0, 32'd0);
    bus_read(4'd0, r);
    check("R11 flushed ctrl", r, 32'h0001_0100);
    check("R11 tvalid", {31'b0, tx_tvalid}, 32'd0);
    bus_write(4'd0, 32'd1);
    @(negedge clk);
    check("R11 tready back", {31'b0, rx_tready}, 32'd1);
    bus_read(4'd4, r);
    check("R11 rx empty", r, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_plain();
    t_tx_last();
    t_no_push();
    t_tx_order();
    t_rx();
    t_rx_empty();
    t_full();
    t_flush();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule